// File: doc/BRIEF.md
# Fast Gate-A20 and Warm-Reset Emulator

This block answers the handful of keyboard-controller port commands that software uses to open the A20 address gate and to reset the processor. The slow external controller no longer sits on that path. It watches a reduced I/O interface (address, write data, write and read strobes) for writes to the command port (64h) and the data port (60h), and for reads of the data port. From those accesses it keeps an emulated gate-A20 state and fires a warm-reset pulse.

A strap input selects emulation. With the strap low the block stays out of the way: port accesses leave its state untouched, and the external controller's gate-A20 and reset lines pass straight through. A second, independent path raises the same reset pulse when a halt cycle is seen while a software-reset control bit is set. The A20 mask handed to the processor combines the external gate with the emulated one. It is forced open while the power-up reset is held.

Top module: `kbcf_fastgate`

## Requirements
- R1: With `fast_en` low, port writes change no emulated state and raise no pulse, reads of 60h are not answered (`io_rvalid`=0, `io_rdata`=00h), `a20_mask` equals `ext_a20` and `warm_rst` equals `ext_rst`.
- R2: With `fast_en` high, writing D1h to port 64h arms the block; the next write to port 60h loads the emulated gate from data bit 1 (1 = open) and disarms.
- R3: A write to port 64h of any value other than D1h cancels the armed state, and a port 60h write while unarmed leaves the gate unchanged.
- R4: With `dly_imm` high, writing FEh to port 64h raises `warm_rst` on the first clock edge after the write edge. It stays high for exactly PULSE_CYC cycles.
- R5: With `dly_imm` low, the FEh pulse starts 2 µs after the write edge, that is 2*CLK_MHZ cycles, and lasts PULSE_CYC cycles.
- R6: With `fast_en` high, a read of 60h asserts `io_rvalid`. `io_rdata` bit 0 is 1 while a reset is pending or being pulsed, bit 1 is the emulated gate, and bits 7:2 are 0.
- R7: With `fast_en` high, `a20_mask` = `ext_a20` AND the emulated gate; while `rst_n` is low `a20_mask` is 1.
- R8: A `halt_cyc` strobe while `soft_rst_en` is high starts a PULSE_CYC pulse on the next edge, whatever `fast_en` is; without `soft_rst_en` a halt does nothing.
- R9: Only one pulse is produced at a time. Triggers during a pulse are dropped, and an immediate trigger cancels a delayed one still waiting.
- R10: After reset the emulated gate is open (1), nothing is armed or pending, and `warm_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| fast_en | input | 1 | Emulation strap |
| dly_imm | input | 1 | 1: reset pulse immediate, 0: after 2 µs |
| soft_rst_en | input | 1 | Software-reset control bit |
| halt_cyc | input | 1 | One-cycle strobe: halt cycle detected |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Read data for port 60h |
| io_rvalid | output | 1 | Block answers this read |
| ext_a20 | input | 1 | Gate-A20 from external controller |
| ext_rst | input | 1 | Warm reset from external controller |
| a20_gate | output | 1 | Emulated gate-A20 state |
| warm_rst | output | 1 | Warm-reset pulse to the processor |
| a20_mask | output | 1 | Final A20 mask to the processor |

## Verification
The FEh command and the halt-driven software reset share one pulse generator, so both can request a pulse in the same clock. The bench issues FEh with the delay selected and a halt strobe on the same edge. It also sends a halt part-way through a pending 2 µs delay and an FEh command in the middle of an active pulse. The scoreboard holds exactly one expected pulse for each case, with its start cycle and width, and any second or stretched pulse shows up as a mismatch or as an unexpected pulse.

// File: rtl/kbcf_pkg.sv
package kbcf_pkg;
   localparam logic [7:0] CMD_ARM_A20 = 8'hD1;
   localparam logic [7:0] CMD_PULSE   = 8'hFE;

   typedef struct packed {
      logic now;   // start the pulse on the next edge
      logic late;  // start the pulse after the delay window
   } rst_req_t;
endpackage

// File: rtl/kbcf_cmd.sv
module kbcf_cmd
   import kbcf_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_PORT = 'h60,
   parameter int CMD_PORT  = 'h64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   output logic              a20_q,
   output logic              arm_q,
   output logic              pulse_cmd
);
   localparam logic [ADDR_W-1:0] DPORT = ADDR_W'(DATA_PORT);
   localparam logic [ADDR_W-1:0] CPORT = ADDR_W'(CMD_PORT);

   logic wr_cmd, wr_dat;

   assign wr_cmd    = fast_en & io_wr & (io_addr == CPORT);
   assign wr_dat    = fast_en & io_wr & (io_addr == DPORT);
   assign pulse_cmd = wr_cmd & (io_wdata == CMD_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a20_q <= 1'b1;
         arm_q <= 1'b0;
      end else if (!fast_en) begin
         arm_q <= 1'b0;
      end else if (wr_cmd) begin
         arm_q <= (io_wdata == CMD_ARM_A20);
      end else if (wr_dat) begin
         if (arm_q) a20_q <= io_wdata[1];
         arm_q <= 1'b0;
      end
   end
endmodule

// File: rtl/kbcf_rst_gen.sv
module kbcf_rst_gen
   import kbcf_pkg::*;
#(
   parameter int DLY_CYC   = 500,
   parameter int PULSE_CYC = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  rst_req_t req,
   output logic     pulse,
   output logic     pend
);
   localparam int DW = $clog2(DLY_CYC + 1);
   localparam int PW = $clog2(PULSE_CYC + 1);

   logic [DW-1:0] dly_cnt;
   logic          start, pulse_done;

   assign start = !pulse && (req.now || (pend && dly_cnt == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         dly_cnt <= '0;
      end else if (pulse) begin
         pend <= 1'b0;
      end else if (start) begin
         pend <= 1'b0;
      end else if (pend) begin
         dly_cnt <= dly_cnt - 1'b1;
      end else if (req.late) begin
         pend    <= 1'b1;
         dly_cnt <= DW'(DLY_CYC - 1);
      end
   end

   generate
      if (PULSE_CYC == 1) begin : g_single
         assign pulse_done = 1'b1;
      end else begin : g_count
         logic [PW-1:0] p_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     p_cnt <= '0;
            else if (start) p_cnt <= PW'(PULSE_CYC - 1);
            else if (pulse) p_cnt <= p_cnt - 1'b1;
         end
         assign pulse_done = (p_cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pulse <= 1'b0;
      else if (start)               pulse <= 1'b1;
      else if (pulse && pulse_done) pulse <= 1'b0;
   end
endmodule

// File: rtl/kbcf_outmux.sv
module kbcf_outmux #(
   parameter int ADDR_W    = 16,
   parameter int DATA_PORT = 'h60
) (
   input  logic              rst_n,
   input  logic              fast_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              a20_q,
   input  logic              rst_busy,
   input  logic              rst_pulse,
   input  logic              ext_a20,
   input  logic              ext_rst,
   output logic [7:0]        io_rdata,
   output logic              io_rvalid,
   output logic              warm_rst,
   output logic              a20_mask
);
   localparam logic [ADDR_W-1:0] DPORT = ADDR_W'(DATA_PORT);

   always_comb begin
      io_rvalid = fast_en & io_rd & (io_addr == DPORT);
      io_rdata  = io_rvalid ? {6'b0, a20_q, rst_busy} : 8'h00;
      warm_rst  = rst_pulse | (!fast_en & ext_rst);
      a20_mask  = !rst_n | (ext_a20 & (a20_q | !fast_en));
   end
endmodule

// File: rtl/kbcf_fastgate.sv
module kbcf_fastgate
   import kbcf_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_PORT = 'h60,
   parameter int CMD_PORT  = 'h64,
   parameter int CLK_MHZ   = 250,
   parameter int PULSE_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_en,
   input  logic              dly_imm,
   input  logic              soft_rst_en,
   input  logic              halt_cyc,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   output logic              io_rvalid,
   input  logic              ext_a20,
   input  logic              ext_rst,
   output logic              a20_gate,
   output logic              warm_rst,
   output logic              a20_mask
);
   localparam int DLY_CYC = 2 * CLK_MHZ;

   if (CLK_MHZ < 1)   begin : g_bad_clk   $error("CLK_MHZ must be at least 1"); end
   if (PULSE_CYC < 1) begin : g_bad_pulse $error("PULSE_CYC must be at least 1"); end
   if (ADDR_W < 8)    begin : g_bad_addr  $error("ADDR_W must hold port 64h"); end
   if (DATA_PORT == CMD_PORT) begin : g_bad_port $error("ports must differ"); end

   logic     a20_q, arm_q, pulse_cmd, rst_pulse, rst_pend;
   rst_req_t req;

   kbcf_cmd #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_cmd (
      .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_wr(io_wr), .a20_q(a20_q), .arm_q(arm_q),
      .pulse_cmd(pulse_cmd)
   );

   always_comb begin
      req.now  = (pulse_cmd & dly_imm) | (halt_cyc & soft_rst_en);
      req.late = pulse_cmd & !dly_imm;
   end

   kbcf_rst_gen #(.DLY_CYC(DLY_CYC), .PULSE_CYC(PULSE_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .req(req), .pulse(rst_pulse), .pend(rst_pend)
   );

   kbcf_outmux #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT)) u_out (
      .rst_n(rst_n), .fast_en(fast_en), .io_addr(io_addr), .io_rd(io_rd),
      .a20_q(a20_q), .rst_busy(rst_pend | rst_pulse), .rst_pulse(rst_pulse),
      .ext_a20(ext_a20), .ext_rst(ext_rst), .io_rdata(io_rdata),
      .io_rvalid(io_rvalid), .warm_rst(warm_rst), .a20_mask(a20_mask)
   );

   assign a20_gate = a20_q;
endmodule

// File: rtl/kbcf_chk.sv
module kbcf_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_PORT = 'h60,
   parameter int CMD_PORT  = 'h64,
   parameter int PULSE_CYC = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fast_en,
   input logic              dly_imm,
   input logic              soft_rst_en,
   input logic              halt_cyc,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              io_rvalid,
   input logic              ext_a20,
   input logic              ext_rst,
   input logic              warm_rst,
   input logic              a20_mask,
   input logic              a20,
   input logic              arm,
   input logic              pulse
);
   logic [31:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else        run <= pulse ? run + 1 : '0;
   end

   assert_pass_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_en |-> (a20_mask == ext_a20));
   assert_pass_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_en && !pulse) |-> (warm_rst == ext_rst));
   assert_load_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_en && arm && io_wr && io_addr == ADDR_W'(DATA_PORT)) |=> (a20 == $past(io_wdata[1])));
   assert_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_en && !arm && io_wr && io_addr == ADDR_W'(DATA_PORT)) |=> $stable(a20));
   assert_imm_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_en && dly_imm && !pulse && io_wr && io_addr == ADDR_W'(CMD_PORT) && io_wdata == 8'hFE) |=> pulse);
   assert_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_en && io_rd && io_addr == ADDR_W'(DATA_PORT)) |-> (io_rvalid && io_rdata[7:2] == 6'd0 && io_rdata[1] == a20));
   assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_cyc && soft_rst_en && !pulse) |=> pulse);
   assert_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> (run < PULSE_CYC));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_mask_open_R7: assert (a20_mask);
      end
   end
endmodule

bind kbcf_fastgate kbcf_chk #(
   .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT), .PULSE_CYC(PULSE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .dly_imm(dly_imm),
   .soft_rst_en(soft_rst_en), .halt_cyc(halt_cyc), .io_addr(io_addr),
   .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
   .io_rvalid(io_rvalid), .ext_a20(ext_a20), .ext_rst(ext_rst),
   .warm_rst(warm_rst), .a20_mask(a20_mask), .a20(a20_q), .arm(arm_q),
   .pulse(rst_pulse)
);

// File: tb/test_kbcf_fastgate.sv
module test_kbcf_fastgate;
   localparam int ADDR_W = 16;
   localparam int PCYC   = 16;
   localparam int DCYC   = 500;   // 2 us at 250 MHz

   logic clk = 1'b0, rst_n = 1'b0, fast_en = 1'b1, dly_imm = 1'b1;
   logic soft_rst_en = 1'b0, halt_cyc = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
   logic [ADDR_W-1:0] io_addr = '0;
   logic [7:0] io_wdata = '0, io_rdata;
   logic io_rvalid, ext_a20 = 1'b0, ext_rst = 1'b0, a20_gate, warm_rst, a20_mask;

   int cyc = 0, n_chk = 0, n_bad = 0;
   bit done = 0;
   int exp_q[$];          // expected pulse: start cycle
   int wid_q[$];          // expected pulse: width

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   kbcf_fastgate #(.ADDR_W(ADDR_W), .CLK_MHZ(250), .PULSE_CYC(PCYC)) i_kbcf_fastgate (
      .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .dly_imm(dly_imm),
      .soft_rst_en(soft_rst_en), .halt_cyc(halt_cyc), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
      .io_rvalid(io_rvalid), .ext_a20(ext_a20), .ext_rst(ext_rst),
      .a20_gate(a20_gate), .warm_rst(warm_rst), .a20_mask(a20_mask)
   );

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic push(int start, int width);
      exp_q.push_back(start);
      wid_q.push_back(width);
   endtask

   // write; s returns the cycle count just after the sampling edge
   task automatic wr(int addr, int data, bit halt, output int s);
      @(negedge clk);
      s = cyc + 1;
      io_addr = ADDR_W'(addr); io_wdata = 8'(data); io_wr = 1'b1; halt_cyc = halt;
      @(negedge clk);
      io_wr = 1'b0; halt_cyc = 1'b0;
   endtask

   task automatic rd(string tag, int exp_data, bit exp_vld);
      @(negedge clk);
      io_addr = ADDR_W'('h60); io_rd = 1'b1;
      @(posedge clk); #1;
      check({tag, " rdata"}, io_rdata, exp_data);
      check({tag, " rvalid"}, io_rvalid, exp_vld);
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: measures each warm_rst pulse and compares it with the queue
   int p_start = 0, p_wid = 0;
   bit p_prev = 0;
   always @(posedge clk) begin
      #1;
      if (warm_rst && !p_prev) begin p_start = cyc; p_wid = 0; end
      if (warm_rst) p_wid++;
      if (!warm_rst && p_prev) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R9 unexpected pulse: start %0d width %0d expected none", p_start, p_wid);
         end else begin
            check("R4/R5/R8 pulse start", p_start, exp_q.pop_front());
            check("R4/R5/R8 pulse width", p_wid, wid_q.pop_front());
         end
      end
      p_prev = warm_rst;
   end

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int s, s2;
      idle(3);
      check("R7 mask open in reset", a20_mask, 1);
      check("R10 no pulse in reset", warm_rst, 0);
      @(negedge clk) rst_n = 1'b1;
      rd("R10 reset gate open", 8'h02, 1);
      check("R7 ext low closes mask", a20_mask, 0);
      ext_a20 = 1'b1;
      // R2
      wr('h64, 'hD1, 0, s); wr('h60, 'h00, 0, s);
      rd("R2 close gate", 8'h00, 1);
      check("R7 emulated low closes mask", a20_mask, 0);
      wr('h64, 'hD1, 0, s); wr('h60, 'hFF, 0, s);
      rd("R2 open gate", 8'h02, 1);
      check("R7 both open", a20_mask, 1);
      wr('h64, 'hD1, 0, s); wr('h60, 'hFD, 0, s);
      rd("R2 bit1 only", 8'h00, 1);
      wr('h64, 'hD1, 0, s); wr('h60, 'h02, 0, s);
      wr('h60, 'h00, 0, s);
      rd("R2 arm consumed", 8'h02, 1);
      // R3
      wr('h64, 'hD1, 0, s); wr('h64, 'hAA, 0, s); wr('h60, 'h00, 0, s);
      rd("R3 arm cancelled", 8'h02, 1);
      // R1
      fast_en = 1'b0; ext_a20 = 1'b0;
      wr('h64, 'hD1, 0, s); wr('h60, 'h00, 0, s); wr('h64, 'hFE, 0, s);
      rd("R1 read ignored", 8'h00, 0);
      check("R1 mask follows ext low", a20_mask, 0);
      ext_a20 = 1'b1;
      idle(1);
      check("R1 mask follows ext high", a20_mask, 1);
      @(negedge clk); s = cyc + 1; ext_rst = 1'b1;
      push(s, 3); idle(3); ext_rst = 1'b0;
      idle(30);
      @(negedge clk) fast_en = 1'b1;
      rd("R1 gate untouched", 8'h02, 1);
      // R4 immediate, R6 busy bit
      wr('h64, 'hFE, 0, s); push(s, PCYC);
      rd("R6 busy during pulse", 8'h03, 1);
      idle(PCYC + 10);
      rd("R6 idle after pulse", 8'h02, 1);
      // R5 delayed
      dly_imm = 1'b0;
      wr('h64, 'hFE, 0, s); push(s + DCYC, PCYC);
      rd("R6 busy while pending", 8'h03, 1);
      idle(DCYC + PCYC + 10);
      // R8
      wr('h70, 'h00, 1, s);          // halt without soft bit
      idle(PCYC + 5);
      soft_rst_en = 1'b1;
      wr('h70, 'h00, 1, s); push(s, PCYC);
      idle(PCYC + 10);
      // R9 same-cycle FEh (delayed) and halt
      wr('h64, 'hFE, 1, s); push(s, PCYC);
      idle(DCYC + PCYC + 20);
      // R9 halt during pending delay
      wr('h64, 'hFE, 0, s);
      idle(8);
      wr('h70, 'h00, 1, s2); push(s2, PCYC);
      idle(DCYC + PCYC + 20);
      // R9 command during active pulse
      dly_imm = 1'b1;
      wr('h64, 'hFE, 0, s); push(s, PCYC);
      wr('h64, 'hFE, 0, s2);
      idle(PCYC + 20);
      check("R9 all expected pulses seen", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule